// File: doc/BRIEF.md
# External bus access wait-state generator

This block sets the length of each access to the external address space. An access-start strobe opens an access. The block then holds a stall line high for a programmable number of extra clock cycles. When the access is over, it raises a single-cycle done pulse. If the wait-enable flag is set, the block can extend the access further: it keeps stretching while an active-low external wait pin stays low after the programmed minimum has run out.

An 8-bit control register holds the settings and is reached through a plain read/write port. The stretch rules apply only in the two expanded bus modes. In the two emulation modes, register traffic is also mirrored to the external bus.

The block carries no data stream, so every pin is a plain control or status line. The stall output acts as the requester's back-pressure: a strobe is accepted only while the block is idle.

Top module: `ext_wait_gen`

## Requirements
- R1: The control register holds the wait-enable flag in bit 7 and the stretch code in bits 2:0. Bits 6:3 always read as zero. After reset it reads 0x07 (code 111, wait disabled). It can be read or written in any cycle, and a read shows a write from an earlier cycle.
- R2: `mode_i` bit 0 selects expanded operation and bit 1 selects emulation. The codes are 00 normal single-chip, 01 normal expanded, 10 emulation single-chip and 11 emulation expanded. In modes 00 and 10 an access is not stretched: stall is high only in the strobe cycle, done follows in the next cycle, and the wait pin has no effect.
- R3: In an expanded mode with wait disabled, the stretch is S = code + 1, from 1 to 8. Stall is high in the strobe cycle and the S cycles after it, and done comes S+1 cycles after the strobe. The wait pin has no effect.
- R4: In an expanded mode with wait enabled, codes 000 and 001 both give a minimum stretch of 2.
- R5: In an expanded mode with wait enabled, codes 010 to 111 give a minimum stretch of code + 1, from 3 to 8.
- R6: When wait is active, the block samples `xwait_n_i` at the clock edge that ends the last minimum cycle, and at each later edge. Every low sample adds one cycle. Done follows the first cycle in which the pin is sampled high.
- R7: Done lasts exactly one cycle and occurs with stall low. When no access is in progress and no strobe is present, stall and done are both low.
- R8: A strobe that arrives while an access is still stretching is ignored and does not change that access's length. Every accepted strobe is timed by the rules above.
- R9: An access uses the register value that held at its strobe cycle. A write made in the strobe cycle or later affects only the next access.
- R10: In modes 10 and 11, a register write also raises `ext_wr_o` in the same cycle with the written byte on `ext_wr_data_o`, and the internal register is still updated. A read raises `ext_rd_o` and returns `ext_rd_data_i`. In modes 00 and 01, `ext_wr_o` and `ext_rd_o` stay low and reads return the internal register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Bus operating mode (bit 0 expanded, bit 1 emulation) |
| cfg_wr_en_i | input | 1 | Register write strobe |
| cfg_rd_en_i | input | 1 | Register read strobe |
| cfg_wdata_i | input | 8 | Register write data |
| cfg_rdata_o | output | 8 | Register read data (combinational) |
| ext_wr_o | output | 1 | Mirrored write to the external bus |
| ext_rd_o | output | 1 | Read directed to the external bus |
| ext_wr_data_o | output | 8 | Data of the mirrored write |
| ext_rd_data_i | input | 8 | Data returned by the external bus on a read |
| acc_start_i | input | 1 | Start of an external access, one cycle |
| xwait_n_i | input | 1 | External wait request, active low |
| stall_o | output | 1 | Requester must hold while high |
| done_o | output | 1 | One-cycle pulse at access end |

## Verification
A wrong remaining-count register or latched stretch value shows up at the ports as a done pulse that arrives early or late. The error is visible on the very access where it occurs, because the bench measures the distance from strobe to done for each access and checks stall on every cycle in between. A corrupted latched wait flag shows up on the first wait-pin pattern that straddles the end of the minimum: the block either extends an access it should not, or fails to extend one it should. A register holding the wrong value shows up on the next read, or on the length of the next access.

// File: rtl/wsg_pkg.sv
package wsg_pkg;
  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_SINGLE     = 2'b00,
    MODE_NORM_EXP   = 2'b01,
    MODE_EMU_SINGLE = 2'b10,
    MODE_EMU_EXP    = 2'b11
  } bus_mode_e;

  function automatic logic mode_is_expanded(bus_mode_e m);
    return (m == MODE_NORM_EXP) || (m == MODE_EMU_EXP);
  endfunction

  function automatic logic mode_is_emul(bus_mode_e m);
    return (m == MODE_EMU_SINGLE) || (m == MODE_EMU_EXP);
  endfunction
endpackage

// File: rtl/wsg_cfg_reg.sv
module wsg_cfg_reg #(
  parameter int DATA_W = 8,
  parameter int CODE_W = 3,
  parameter int EN_BIT = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              emul,
  input  logic [DATA_W-1:0] ext_rdata,
  output logic [DATA_W-1:0] rdata,
  output logic              ext_wr,
  output logic              ext_rd,
  output logic [DATA_W-1:0] ext_wdata,
  output logic              wait_en,
  output logic [CODE_W-1:0] code
);
  localparam logic [DATA_W-1:0] LIVE_MASK =
    (DATA_W'(1) << EN_BIT) | DATA_W'((1 << CODE_W) - 1);

  logic [DATA_W-1:0] local_view;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_en <= 1'b0;
      code    <= '1;
    end else if (wr_en) begin
      wait_en <= wdata[EN_BIT];
      code    <= wdata[CODE_W-1:0];
    end
  end

  always_comb begin
    local_view                = '0;
    local_view[EN_BIT]        = wait_en;
    local_view[CODE_W-1:0]    = code;
  end

  assign rdata     = emul ? ext_rdata : local_view;
  assign ext_wr    = wr_en & emul;
  assign ext_rd    = rd_en & emul;
  assign ext_wdata = wdata;

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !emul |-> ((rdata & ~LIVE_MASK) == '0)); // R1
endmodule

// File: rtl/wsg_stretch_calc.sv
module wsg_stretch_calc #(
  parameter int CODE_W     = 3,
  parameter int CNT_W      = 4,
  parameter int WAIT_FLOOR = 2
) (
  input  logic              expanded,
  input  logic              wait_en,
  input  logic [CODE_W-1:0] code,
  output logic [CNT_W-1:0]  min_cnt,
  output logic              wait_act
);
  logic [CNT_W-1:0] base;

  always_comb begin
    base = CNT_W'(code) + CNT_W'(1);
    if (wait_en && (base < CNT_W'(WAIT_FLOOR)))
      base = CNT_W'(WAIT_FLOOR);
    min_cnt  = expanded ? base : '0;
    wait_act = expanded & wait_en;
  end
endmodule

// File: rtl/wsg_seq.sv
module wsg_seq #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] min_cnt,
  input  logic             wait_act,
  input  logic             xwait_n,
  output logic             busy,
  output logic             stall,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;
  logic             wait_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      cnt_q  <= '0;
      wait_q <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          if (min_cnt == '0) begin
            done <= 1'b1;
          end else begin
            busy   <= 1'b1;
            cnt_q  <= min_cnt;
            wait_q <= wait_act;
          end
        end
      end else if (cnt_q > CNT_W'(1)) begin
        cnt_q <= cnt_q - CNT_W'(1);
      end else if (!(wait_q && !xwait_n)) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  assign stall = busy | start;

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R7
  AST_CNT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt_q != '0)); // R3
  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start)); // R8
  AST_WAIT_EXTENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt_q == CNT_W'(1) && wait_q && !xwait_n) |=> (busy && !done)); // R6
  AST_STROBE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && cnt_q > CNT_W'(1)) |=> (busy && cnt_q == $past(cnt_q) - CNT_W'(1))); // R8
endmodule

// File: rtl/ext_wait_gen.sv
module ext_wait_gen #(
  parameter int DATA_W     = 8,
  parameter int CODE_W     = 3,
  parameter int EN_BIT     = 7,
  parameter int WAIT_FLOOR = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic              cfg_wr_en_i,
  input  logic              cfg_rd_en_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  output logic [DATA_W-1:0] cfg_rdata_o,
  output logic              ext_wr_o,
  output logic              ext_rd_o,
  output logic [DATA_W-1:0] ext_wr_data_o,
  input  logic [DATA_W-1:0] ext_rd_data_i,
  input  logic              acc_start_i,
  input  logic              xwait_n_i,
  output logic              stall_o,
  output logic              done_o
);
  import wsg_pkg::*;

  localparam int CNT_W = $clog2((1 << CODE_W) + 1);

  bus_mode_e        mode;
  logic             expanded;
  logic             emul;
  logic             cfg_wait_en;
  logic [CODE_W-1:0] cfg_code;
  logic [CNT_W-1:0] min_cnt;
  logic             wait_act;
  logic             busy;

  assign mode     = bus_mode_e'(mode_i);
  assign expanded = mode_is_expanded(mode);
  assign emul     = mode_is_emul(mode);

  wsg_cfg_reg #(.DATA_W(DATA_W), .CODE_W(CODE_W), .EN_BIT(EN_BIT)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_wr_en_i),
    .rd_en     (cfg_rd_en_i),
    .wdata     (cfg_wdata_i),
    .emul      (emul),
    .ext_rdata (ext_rd_data_i),
    .rdata     (cfg_rdata_o),
    .ext_wr    (ext_wr_o),
    .ext_rd    (ext_rd_o),
    .ext_wdata (ext_wr_data_o),
    .wait_en   (cfg_wait_en),
    .code      (cfg_code)
  );

  wsg_stretch_calc #(.CODE_W(CODE_W), .CNT_W(CNT_W), .WAIT_FLOOR(WAIT_FLOOR)) u_calc (
    .expanded (expanded),
    .wait_en  (cfg_wait_en),
    .code     (cfg_code),
    .min_cnt  (min_cnt),
    .wait_act (wait_act)
  );

  wsg_seq #(.CNT_W(CNT_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (acc_start_i),
    .min_cnt  (min_cnt),
    .wait_act (wait_act),
    .xwait_n  (xwait_n_i),
    .busy     (busy),
    .stall    (stall_o),
    .done     (done_o)
  );

  AST_WAIT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (expanded && cfg_wait_en) |-> (min_cnt >= CNT_W'(WAIT_FLOOR))); // R4
  AST_PLAIN_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_start_i && !busy && !expanded) |=> done_o); // R2
  AST_WR_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en_i && emul) |-> (ext_wr_o && ext_wr_data_o == cfg_wdata_i)); // R10
endmodule

// File: tb/ext_wait_gen_test.sv
module ext_wait_gen_test;
  localparam time PERIOD = 20ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode_i = 2'b01;
  logic       cfg_wr_en_i = 1'b0;
  logic       cfg_rd_en_i = 1'b0;
  logic [7:0] cfg_wdata_i = '0;
  logic [7:0] cfg_rdata_o;
  logic       ext_wr_o;
  logic       ext_rd_o;
  logic [7:0] ext_wr_data_o;
  logic [7:0] ext_rd_data_i = 8'h5A;
  logic       acc_start_i = 1'b0;
  logic       xwait_n_i = 1'b1;
  logic       stall_o;
  logic       done_o;

  int checks = 0;
  int errors = 0;
  logic       m_en = 1'b0;
  logic [2:0] m_code = 3'b111;
  int    exp_q[$];
  string tag_q[$];

  always #(PERIOD/2) clk = ~clk;

  ext_wait_gen uut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
    .cfg_wr_en_i(cfg_wr_en_i), .cfg_rd_en_i(cfg_rd_en_i),
    .cfg_wdata_i(cfg_wdata_i), .cfg_rdata_o(cfg_rdata_o),
    .ext_wr_o(ext_wr_o), .ext_rd_o(ext_rd_o),
    .ext_wr_data_o(ext_wr_data_o), .ext_rd_data_i(ext_rd_data_i),
    .acc_start_i(acc_start_i), .xwait_n_i(xwait_n_i),
    .stall_o(stall_o), .done_o(done_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Monitor: measures each access from strobe to done, checks stall on the way
  bit active = 0;
  int len = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (active) begin
        len++;
        if (done_o) begin
          active = 0;
          if (exp_q.size() == 0) begin
            check(0, "R7 unexpected done", len, 0);
          end else begin
            automatic int e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            check(len == e && !stall_o, t, len, e);
          end
        end else if (!stall_o) begin
          check(0, "R7 stall dropped early", len, 1);
        end else if (len > 64) begin
          active = 0;
          void'(exp_q.pop_front());
          check(0, tag_q.pop_front(), len, 0);
        end
      end else if (acc_start_i) begin
        active = 1;
        len = 0;
        check(stall_o == 1'b1, "R7 stall in strobe cycle", stall_o, 1);
      end else if (stall_o || done_o) begin
        check(0, "R7 idle outputs", {stall_o, done_o}, 0);
      end
    end
  end

  function automatic int model_min();
    int s;
    if (!mode_i[0]) return 0;
    s = int'(m_code) + 1;
    if (m_en && s < 2) s = 2;
    return s;
  endfunction

  // Driver: pushes the expected length, then drives the access cycle by cycle
  task automatic access(input int w, input int again, input int wr_at,
                        input logic [7:0] wr_val, input string tag);
    automatic int  s    = model_min();
    automatic bit  wact = mode_i[0] && m_en;
    automatic int  e    = s + 1 + (wact ? w : 0);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    for (int k = 0; k <= e; k++) begin
      @(posedge clk); #1;
      acc_start_i = (k == 0) || (k == again);
      xwait_n_i   = wact ? !(k >= s && k < s + w) : !(w > 0);
      cfg_wr_en_i = (k == wr_at);
      cfg_wdata_i = wr_val;
    end
    if (wr_at >= 0) begin
      m_en = wr_val[7];
      m_code = wr_val[2:0];
    end
    @(posedge clk); #1;
    acc_start_i = 0;
    cfg_wr_en_i = 0;
    xwait_n_i   = 1;
  endtask

  task automatic wr(input logic [7:0] v, input string tag);
    @(posedge clk); #1;
    cfg_wr_en_i = 1;
    cfg_wdata_i = v;
    @(negedge clk);
    if (mode_i[1])
      check(ext_wr_o && ext_wr_data_o == v, tag, ext_wr_data_o, v);
    else
      check(!ext_wr_o, tag, ext_wr_o, 0);
    @(posedge clk); #1;
    cfg_wr_en_i = 0;
    m_en = v[7];
    m_code = v[2:0];
  endtask

  task automatic rd(input logic [7:0] expv, input string tag);
    @(posedge clk); #1;
    cfg_rd_en_i = 1;
    @(negedge clk);
    check(cfg_rdata_o == expv && ext_rd_o == mode_i[1], tag, cfg_rdata_o, expv);
    @(posedge clk); #1;
    cfg_rd_en_i = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check(!stall_o && !done_o, "R7 reset outputs", {stall_o, done_o}, 0);
    rd(8'h07, "R1 reset value");

    // R3: wait disabled, code+1 stretch, wait pin ignored
    access(0, -1, -1, 8'h00, "R3 code 7 wait off");
    access(3, -1, -1, 8'h00, "R3 wait pin ignored when disabled");
    wr(8'h00, "R10 no mirror in mode 01");
    rd(8'h00, "R1 readback 0x00");
    access(0, -1, -1, 8'h00, "R3 code 0 wait off");

    // R4 / R5: wait enabled minimums
    wr(8'h80, "R10 no mirror");
    rd(8'h80, "R1 readback 0x80");
    access(0, -1, -1, 8'h00, "R4 code 0 wait on");
    wr(8'h81, "R10 no mirror");
    access(0, -1, -1, 8'h00, "R4 code 1 wait on");
    wr(8'h82, "R10 no mirror");
    access(0, -1, -1, 8'h00, "R5 code 2 wait on");
    wr(8'hFF, "R10 no mirror");
    rd(8'h87, "R1 reserved bits read zero");
    access(0, -1, -1, 8'h00, "R5 code 7 wait on");

    // R6: extension by the wait pin
    wr(8'h83, "R10 no mirror");
    access(3, -1, -1, 8'h00, "R6 three wait cycles");
    access(1, -1, -1, 8'h00, "R6 one wait cycle");
    wr(8'h80, "R10 no mirror");
    access(5, -1, -1, 8'h00, "R6 floor plus five wait cycles");

    // R2: non-expanded modes
    wr(8'h87, "R10 no mirror");
    mode_i = 2'b00;
    access(2, -1, -1, 8'h00, "R2 single-chip no stretch");
    mode_i = 2'b10;
    access(2, -1, -1, 8'h00, "R2 emulation single-chip no stretch");

    // R8: strobe during access ignored
    mode_i = 2'b01;
    wr(8'h05, "R10 no mirror");
    access(0, 2, -1, 8'h00, "R8 second strobe ignored");

    // R9: writes during an access only affect the next one
    access(0, -1, 3, 8'h00, "R9 mid-access write keeps latch");
    access(0, -1, 0, 8'h03, "R9 strobe-cycle write keeps latch");
    access(0, -1, -1, 8'h00, "R9 new setting on next access");
    rd(8'h03, "R1 read after access write");

    // R10: emulation mirroring
    mode_i = 2'b10;
    rd(8'h5A, "R10 emulation read from bus");
    wr(8'h44, "R10 emulation write mirrored");
    mode_i = 2'b01;
    rd(8'h04, "R10 internal register also written");
    mode_i = 2'b11;
    ext_rd_data_i = 8'hC3;
    rd(8'hC3, "R10 emulation expanded read");
    access(0, -1, -1, 8'h00, "R10 emulation expanded stretched");

    repeat (3) @(posedge clk);
    check(exp_q.size() == 0, "R7 all accesses completed", exp_q.size(), 0);
    finish_run();
  end
endmodule